// File: doc/BRIEF.md
# Per-Frame Message Extraction Controller

This block decides, once per time frame, which of eight incoming buses carry a channel-0 message for a host processor, and hands those messages to the host one at a time. The host writes a non-zero bus mask. That mask is kept in a shadow register and also copied into a working register. Every frame start reloads the working register from the shadow copy. The block then drops each bus whose channel-0 data opens with the idle label, and latches the eight message bytes.

If any bus is still pending when the current routine completes, and the host has read the index register since the last extraction began, the block pulls its active-low ready line low for two cycles. It also publishes the pending count. The host then reads the count, followed by message/bus-number pairs, starting with the highest pending bus. A new frame start drops whatever is left unread and begins again from the shadow mask.

Top module: `msg_extract_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) clears both mask registers, the message register and the index register. It leaves `data_ready_n` high and disarms the block, so later frame starts and routine-done strobes raise no interrupt until a mask is written.
- R2: A host write of a non-zero value loads both the shadow and the working mask and arms the block. A write of zero is ignored completely.
- R3: On `frame_start` while armed, the working mask is reloaded from the shadow mask, and bus i is dropped when its label `start_label[2i+1:2i]` equals 2'b01. Labels 00, 10 and 11 all count as a message. `msg_bytes[8i+7:8i]` is latched for bus i at that same edge, so later changes to it have no effect.
- R4: Extraction starts only on a `routine_done` strobe and only when the pruned working mask is non-zero. An empty mask raises no interrupt.
- R5: When extraction starts, `data_ready_n` is low for exactly two cycles, and the index register holds the number of pending buses.
- R6: While serving, a read of the index register (`host_rsel`=1) after the count, or after a bus number, loads the message register with the next byte and the index register with that bus number. A read of the index register before the message register has been read is ignored.
- R7: Pending buses are served from the highest bus number to the lowest.
- R8: A `frame_start` during extraction ends it at once, with no interrupt in the next cycle, and a fresh extraction may follow from the reloaded mask.
- R9: An extraction may start only if the host has read the index register outside of serving since the previous extraction began. Until then, `routine_done` is ignored.
- R10: A bus's bit leaves the working mask once its bus number has been read. When no bits remain the block goes idle: further `routine_done` strobes raise nothing, and both output registers keep their last values.
- R11: `host_rdata` shows the message register when `host_rsel`=0 and the index register when `host_rsel`=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Start-of-frame strobe |
| routine_done | input | 1 | End of the current routine strobe |
| start_label | input | 16 | Two label bits per bus, bus i at [2i+1:2i] |
| msg_bytes | input | 64 | Channel-0 message byte per bus, bus i at [8i+7:8i] |
| host_wr | input | 1 | Host mask write strobe |
| host_wdata | input | 8 | Mask to store |
| host_rd | input | 1 | Host read strobe |
| host_rsel | input | 1 | 0 = message register, 1 = index register |
| host_rdata | output | 8 | Selected register contents |
| data_ready_n | output | 1 | Active-low two-cycle interrupt request |

## Verification
The checker watches properties on every cycle. It confirms that a low pulse on the ready line never lasts longer or shorter than two cycles, and that the count is already in place when the pulse begins. It also confirms that the working mask never holds a bus the shadow mask lacks, and that a frame start is never followed by an interrupt in the next cycle. The bench scenarios cover the behaviours that only appear as sequences: the highest-first serving order, ignored out-of-order reads, the gating by an earlier index read, the latching of message bytes at frame start, and the abort and restart across frames.

// File: rtl/msgx_pkg.sv
package msgx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_CNT  = 3'd2,
        ST_MSG  = 3'd3,
        ST_BUS  = 3'd4
    } msgx_state_e;

    localparam logic [1:0] IDLE_LABEL = 2'b01;
    localparam int         IRQ_LEN    = 2;
endpackage

// File: rtl/msgx_prune.sv
module msgx_prune
    import msgx_pkg::*;
#(
    parameter int NBUS = 8
) (
    input  logic [NBUS-1:0]   mask,
    input  logic [2*NBUS-1:0] labels,
    output logic [NBUS-1:0]   keep
);
    for (genvar g = 0; g < NBUS; g++) begin : g_bus
        assign keep[g] = mask[g] && (labels[2*g+1 -: 2] != IDLE_LABEL);
    end
endmodule

// File: rtl/msgx_scan.sv
module msgx_scan #(
    parameter int NBUS = 8,
    localparam int BW = (NBUS > 1) ? $clog2(NBUS) : 1,
    localparam int CW = $clog2(NBUS + 1)
) (
    input  logic [NBUS-1:0] vec,
    output logic [BW-1:0]   top_idx,
    output logic            any,
    output logic [CW-1:0]   count
);
    always_comb begin
        top_idx = '0;
        count   = '0;
        for (int i = 0; i < NBUS; i++) begin
            if (vec[i]) begin
                top_idx = BW'(i);
                count   = count + CW'(1);
            end
        end
        any = |vec;
    end
endmodule

// File: rtl/msgx_msg_bank.sv
module msgx_msg_bank #(
    parameter int NBUS = 8,
    parameter int DW   = 8,
    localparam int BW = (NBUS > 1) ? $clog2(NBUS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [DW*NBUS-1:0] din,
    input  logic [BW-1:0]      sel,
    output logic [DW-1:0]      dout
);
    logic [DW-1:0] byte_q [NBUS];

    for (genvar g = 0; g < NBUS; g++) begin : g_slot
        logic [DW-1:0] byte_d;
        always_comb begin
            byte_d = byte_q[g];
            if (load) byte_d = din[DW*g +: DW];
        end
        always_ff @(posedge clk) begin
            if (rst) byte_q[g] <= '0;
            else     byte_q[g] <= byte_d;
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < NBUS; i++) begin
            if (sel == BW'(i)) dout = byte_q[i];
        end
    end
endmodule

// File: rtl/msg_extract_ctrl.sv
module msg_extract_ctrl
    import msgx_pkg::*;
#(
    parameter int NBUS = 8,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               routine_done,
    input  logic [2*NBUS-1:0]  start_label,
    input  logic [DW*NBUS-1:0] msg_bytes,
    input  logic               host_wr,
    input  logic [NBUS-1:0]    host_wdata,
    input  logic               host_rd,
    input  logic               host_rsel,
    output logic [DW-1:0]      host_rdata,
    output logic               data_ready_n
);
    localparam int BW = (NBUS > 1) ? $clog2(NBUS) : 1;
    localparam int CW = $clog2(NBUS + 1);

    typedef struct packed {
        msgx_state_e     st;
        logic [NBUS-1:0] bg;
        logic [NBUS-1:0] work;
        logic [DW-1:0]   msg_reg;
        logic [DW-1:0]   idx_reg;
        logic [BW-1:0]   cur;
        logic [1:0]      irq;
        logic            ack;
        logic            armed;
    } regs_t;

    regs_t r_q, r_d;

    logic [NBUS-1:0] pruned;
    logic [NBUS-1:0] cur_bit;
    logic [NBUS-1:0] pick_src;
    logic [BW-1:0]   top_idx;
    logic            any_left;
    logic [CW-1:0]   pend_cnt;
    logic [DW-1:0]   sel_byte;
    logic            rd_msg;
    logic            rd_idx;

    // Signals brought out for the bound checker.
    logic [DW-1:0]   idx_q;
    logic [NBUS-1:0] work_q;
    logic [NBUS-1:0] bg_q;

    msgx_prune #(.NBUS(NBUS)) i_prune (
        .mask   (r_q.bg),
        .labels (start_label),
        .keep   (pruned)
    );

    assign cur_bit  = NBUS'(1) << r_q.cur;
    assign pick_src = (r_q.st == ST_BUS) ? (r_q.work & ~cur_bit) : r_q.work;

    msgx_scan #(.NBUS(NBUS)) i_scan (
        .vec     (pick_src),
        .top_idx (top_idx),
        .any     (any_left),
        .count   (pend_cnt)
    );

    msgx_msg_bank #(.NBUS(NBUS), .DW(DW)) i_bank (
        .clk  (clk),
        .rst  (rst),
        .load (frame_start && r_q.armed),
        .din  (msg_bytes),
        .sel  (top_idx),
        .dout (sel_byte)
    );

    assign rd_msg = host_rd && !host_rsel;
    assign rd_idx = host_rd &&  host_rsel;

    always_comb begin
        r_d = r_q;
        if (r_q.irq != 2'd0) r_d.irq = r_q.irq - 2'd1;

        if (frame_start) begin
            if (r_q.armed) begin
                r_d.work = pruned;
                r_d.irq  = 2'd0;
                r_d.st   = (|pruned) ? ST_WAIT : ST_IDLE;
            end
        end else if (host_wr && (|host_wdata)) begin
            r_d.bg    = host_wdata;
            r_d.work  = host_wdata;
            r_d.armed = 1'b1;
            r_d.irq   = 2'd0;
            r_d.st    = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (rd_idx) r_d.ack = 1'b1;
                end
                ST_WAIT: begin
                    if (rd_idx) r_d.ack = 1'b1;
                    if (routine_done && r_q.ack) begin
                        r_d.irq     = 2'(IRQ_LEN);
                        r_d.idx_reg = DW'(pend_cnt);
                        r_d.ack     = 1'b0;
                        r_d.st      = ST_CNT;
                    end
                end
                ST_CNT: begin
                    if (rd_idx) begin
                        r_d.msg_reg = sel_byte;
                        r_d.idx_reg = DW'(top_idx);
                        r_d.cur     = top_idx;
                        r_d.st      = ST_MSG;
                    end
                end
                ST_MSG: begin
                    if (rd_msg) r_d.st = ST_BUS;
                end
                ST_BUS: begin
                    if (rd_idx) begin
                        r_d.work = r_q.work & ~cur_bit;
                        if (any_left) begin
                            r_d.msg_reg = sel_byte;
                            r_d.idx_reg = DW'(top_idx);
                            r_d.cur     = top_idx;
                            r_d.st      = ST_MSG;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign host_rdata   = host_rsel ? r_q.idx_reg : r_q.msg_reg;
    assign data_ready_n = (r_q.irq == 2'd0);

    assign idx_q  = r_q.idx_reg;
    assign work_q = r_q.work;
    assign bg_q   = r_q.bg;
endmodule

// File: rtl/msgx_checker.sv
module msgx_checker #(
    parameter int NBUS = 8,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            frame_start,
    input logic            data_ready_n,
    input logic [DW-1:0]   idx_q,
    input logic [NBUS-1:0] work_q,
    input logic [NBUS-1:0] bg_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> data_ready_n);

    // R5
    irq_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(data_ready_n) |=> !data_ready_n);

    // R5
    irq_max_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_ready_n && $past(!data_ready_n)) |=> data_ready_n);

    // R5
    irq_count_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(data_ready_n) |-> (idx_q == DW'($countones(work_q))));

    // R3
    work_subset_chk: assert property (@(posedge clk) disable iff (rst)
        ((work_q & ~bg_q) == '0));

    // R8
    frame_abort_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> data_ready_n);
endmodule

bind msg_extract_ctrl msgx_checker #(.NBUS(NBUS), .DW(DW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .data_ready_n (data_ready_n),
    .idx_q        (idx_q),
    .work_q       (work_q),
    .bg_q         (bg_q)
);

// File: tb/test_msg_extract_ctrl.sv
module test_msg_extract_ctrl;
    localparam int NBUS = 8;
    localparam int DW   = 8;
    localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_FRM = 3'd2,
                           OP_DONE = 3'd3, OP_RD1 = 3'd4, OP_RD2 = 3'd5;
    localparam int NV = 67;

    // {op, arg, expected, requirement number}
    localparam logic [30:0] VECS [NV] = '{
        {OP_RD2, 16'h0000, 8'h00, 4'd1},   // R1 reset index
        {OP_RD1, 16'h0000, 8'h00, 4'd1},   // R1 reset message
        {OP_IDLE,16'h0000, 8'h01, 4'd1},   // R1 ready high
        {OP_WR,  16'h00A5, 8'h00, 4'd2},   // R2 mask 7,5,2,0
        {OP_FRM, 16'h8403, 8'h00, 4'd3},   // R3 bus5 idle, bus7=10, bus0=11
        {OP_IDLE,16'h0000, 8'h01, 4'd4},   // R4 waits for routine end
        {OP_DONE,16'h0000, 8'h00, 4'd4},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},   // R5 pulse cycle 1
        {OP_IDLE,16'h0000, 8'h00, 4'd5},   // R5 pulse cycle 2
        {OP_IDLE,16'h0000, 8'h01, 4'd5},   // R5 pulse over
        {OP_RD2, 16'h0000, 8'h03, 4'd3},   // R3 count 3
        {OP_RD1, 16'h0000, 8'hC7, 4'd7},   // R7 bus 7 first
        {OP_RD2, 16'h0000, 8'h07, 4'd7},
        {OP_RD1, 16'h0000, 8'hC2, 4'd6},   // R6
        {OP_RD2, 16'h0000, 8'h02, 4'd7},   // R7
        {OP_RD1, 16'h0000, 8'hC0, 4'd6},
        {OP_RD2, 16'h0000, 8'h00, 4'd10},  // R10 last pair
        {OP_DONE,16'h0000, 8'h00, 4'd10},
        {OP_IDLE,16'h0000, 8'h01, 4'd10},  // R10 no restart
        {OP_RD1, 16'h0000, 8'hC0, 4'd10},  // R10 holds
        {OP_FRM, 16'h0000, 8'h00, 4'd3},
        {OP_RD2, 16'h0000, 8'h00, 4'd9},   // R9 enabling read
        {OP_DONE,16'h0000, 8'h00, 4'd5},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},
        {OP_IDLE,16'h0000, 8'h01, 4'd5},
        {OP_RD2, 16'h0000, 8'h04, 4'd3},   // R3 reload from shadow
        {OP_RD2, 16'h0000, 8'h07, 4'd6},   // R6 out of order, ignored
        {OP_RD1, 16'h0000, 8'hC7, 4'd6},
        {OP_FRM, 16'h0000, 8'h00, 4'd8},   // R8 abort
        {OP_IDLE,16'h0000, 8'h01, 4'd8},
        {OP_RD1, 16'h0000, 8'hC7, 4'd8},
        {OP_DONE,16'h0000, 8'h00, 4'd9},   // R9 no enabling read yet
        {OP_IDLE,16'h0000, 8'h01, 4'd9},
        {OP_IDLE,16'h0000, 8'h01, 4'd9},
        {OP_RD2, 16'h0000, 8'h07, 4'd9},
        {OP_DONE,16'h0000, 8'h00, 4'd8},
        {OP_IDLE,16'h0000, 8'h00, 4'd8},   // R8 restart
        {OP_IDLE,16'h0000, 8'h00, 4'd8},
        {OP_RD2, 16'h0000, 8'h04, 4'd8},
        {OP_RD1, 16'h0000, 8'hC7, 4'd8},
        {OP_WR,  16'h0000, 8'h00, 4'd2},   // R2 zero write ignored
        {OP_RD2, 16'h0000, 8'h07, 4'd6},
        {OP_RD1, 16'h0000, 8'hC5, 4'd7},   // R7 bus 5 next
        {OP_RD2, 16'h0000, 8'h05, 4'd7},
        {OP_FRM, 16'h5555, 8'h00, 4'd4},   // R4 every label idle
        {OP_RD2, 16'h0000, 8'h02, 4'd4},
        {OP_DONE,16'h0000, 8'h00, 4'd4},
        {OP_IDLE,16'h0000, 8'h01, 4'd4},
        {OP_FRM, 16'h0000, 8'h00, 4'd2},
        {OP_RD2, 16'h0000, 8'h02, 4'd9},
        {OP_DONE,16'h0000, 8'h00, 4'd2},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},
        {OP_RD2, 16'h0000, 8'h04, 4'd2},   // R2 mask kept after zero write
        {OP_RD1, 16'h0000, 8'hC7, 4'd11},  // R11 select message
        {OP_WR,  16'h0018, 8'h00, 4'd2},   // R2 new mask 4,3
        {OP_FRM, 16'h0000, 8'h00, 4'd3},
        {OP_RD2, 16'h0000, 8'h07, 4'd11},  // R11 select index
        {OP_DONE,16'h0000, 8'h00, 4'd5},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},
        {OP_IDLE,16'h0000, 8'h00, 4'd5},
        {OP_RD2, 16'h0000, 8'h02, 4'd2},
        {OP_RD1, 16'h0000, 8'hC4, 4'd7},
        {OP_RD2, 16'h0000, 8'h04, 4'd7},
        {OP_RD1, 16'h0000, 8'hC3, 4'd6},
        {OP_RD2, 16'h0000, 8'h03, 4'd10}
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               frame_start, routine_done;
    logic [2*NBUS-1:0]  start_label;
    logic [DW*NBUS-1:0] msg_bytes;
    logic               host_wr, host_rd, host_rsel;
    logic [NBUS-1:0]    host_wdata;
    logic [DW-1:0]      host_rdata;
    logic               data_ready_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    msg_extract_ctrl #(.NBUS(NBUS), .DW(DW)) i_msg_extract_ctrl (
        .clk(clk), .rst(rst), .frame_start(frame_start), .routine_done(routine_done),
        .start_label(start_label), .msg_bytes(msg_bytes), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rsel(host_rsel),
        .host_rdata(host_rdata), .data_ready_n(data_ready_n)
    );

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            report();
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_inputs;
        frame_start = 0; routine_done = 0; host_wr = 0; host_rd = 0;
        host_rsel = 0; host_wdata = '0; start_label = '0;
    endtask

    task automatic do_step(input logic [2:0] op, input logic [15:0] arg,
                           input logic [7:0] exp, input string req);
        case (op)
            OP_WR:   begin host_wr = 1; host_wdata = arg[7:0]; end
            OP_FRM:  begin frame_start = 1; start_label = arg; end
            OP_DONE: routine_done = 1;
            OP_RD1:  begin host_rd = 1; host_rsel = 0; end
            OP_RD2:  begin host_rd = 1; host_rsel = 1; end
            default: ;
        endcase
        #1;
        if (op == OP_RD1 || op == OP_RD2) check(req, host_rdata, exp);
        if (op == OP_IDLE) check(req, {7'd0, data_ready_n}, exp);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic set_default_msgs;
        for (int i = 0; i < NBUS; i++) msg_bytes[8*i +: 8] = 8'hC0 | 8'(i);
    endtask

    initial begin
        rst = 1;
        clear_inputs();
        set_default_msgs();
        @(negedge clk);
        @(negedge clk);
        rst = 0;

        for (int v = 0; v < NV; v++) begin
            do_step(VECS[v][30:28], VECS[v][27:12], VECS[v][11:4],
                    $sformatf("R%0d", VECS[v][3:0]));
        end

        // R1: reset mid-extraction clears registers and disarms
        do_step(OP_WR, 16'h00FF, 8'h00, "R1");
        do_step(OP_FRM, 16'h0000, 8'h00, "R1");
        do_step(OP_RD2, 16'h0000, 8'h03, "R1");
        do_step(OP_DONE, 16'h0000, 8'h00, "R1");
        do_step(OP_IDLE, 16'h0000, 8'h00, "R1");
        rst = 1;
        @(negedge clk);
        rst = 0;
        do_step(OP_IDLE, 16'h0000, 8'h01, "R1");
        do_step(OP_RD1, 16'h0000, 8'h00, "R1");
        do_step(OP_RD2, 16'h0000, 8'h00, "R1");
        do_step(OP_FRM, 16'h0000, 8'h00, "R1");
        do_step(OP_RD2, 16'h0000, 8'h00, "R1");
        do_step(OP_DONE, 16'h0000, 8'h00, "R1");
        do_step(OP_IDLE, 16'h0000, 8'h01, "R1");
        do_step(OP_IDLE, 16'h0000, 8'h01, "R1");

        // R3: message byte latched at frame start, later input change ignored
        do_step(OP_WR, 16'h0001, 8'h00, "R3");
        msg_bytes[7:0] = 8'h5A;
        do_step(OP_FRM, 16'h0000, 8'h00, "R3");
        msg_bytes[7:0] = 8'h00;
        do_step(OP_RD2, 16'h0000, 8'h00, "R3");
        do_step(OP_DONE, 16'h0000, 8'h00, "R3");
        do_step(OP_IDLE, 16'h0000, 8'h00, "R5");
        do_step(OP_IDLE, 16'h0000, 8'h00, "R5");
        do_step(OP_RD2, 16'h0000, 8'h01, "R3");
        do_step(OP_RD1, 16'h0000, 8'h5A, "R3");
        do_step(OP_RD2, 16'h0000, 8'h00, "R10");
        do_step(OP_DONE, 16'h0000, 8'h00, "R10");
        do_step(OP_IDLE, 16'h0000, 8'h01, "R10");

        report();
    end
endmodule